// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits on a 16-bit CPU address bus with 8-bit data and turns CPU writes into the lower half of the address space (0x0000-0x7FFF) into control-register updates. From those registers it maps the CPU address onto a physical ROM address and a physical external-RAM address. The fixed window at 0x0000-0x3FFF always shows ROM bank 0. The switchable window at 0x4000-0x7FFF shows the selected bank. The external RAM window at 0xA000-0xBFFF is gated by a software-controlled enable.

The bank number has a 5-bit lower field and a 2-bit upper register. A mode bit steers the 2-bit register: in mode 0 it supplies ROM bank bits [6:5]; in mode 1 it becomes the RAM bank number. A lower field of zero is replaced by one. The ROM size is a power-of-two bank count, with 128 banks at most. A bank number beyond that size wraps. ROM and RAM storage sit outside the block. RAM read data passes through it, so that a disabled window reads as 0xFF.

Top module: `mbc_bank_ctrl`

## Requirements
- R1: A write to 0x0000-0x1FFF with data 0x0A sets the RAM enable. Data 0x00 clears it. Any other data value leaves the enable as it was.
- R2: A write to 0x2000-0x3FFF loads data[4:0] as ROM bank bits [4:0], with 0 replaced by 1. ROM bank bits [6:5] stay unchanged.
- R3: In mode 0, a write to 0x4000-0x5FFF loads data[1:0] as ROM bank bits [6:5]. The RAM bank stays 0.
- R4: In mode 1, a write to 0x4000-0x5FFF loads data[1:0] as the RAM bank, which appears on ram_addr_o[14:13]. ROM bank bits [6:5] read as 0.
- R5: A write to 0x6000-0x7FFF sets the mode from data[0]. A change of mode clears the 2-bit register, so entering mode 1 zeroes ROM bits [6:5] and entering mode 0 zeroes the RAM bank. Rewriting the current mode keeps the register.
- R6: For addresses 0x0000-0x3FFF, rom_addr_o is {0, addr[13:0]}, which is bank 0.
- R7: For addresses 0x4000-0x7FFF, rom_addr_o is {bank & (ROM_BANKS-1), addr[13:0]}.
- R8: For addresses 0xA000-0xBFFF, ram_ce_o is high only while RAM is enabled, and then ram_addr_o is {ram_bank, addr[12:0]}. While RAM is disabled, rdata_o is 0xFF and ram_we_o stays low. While RAM is enabled, rdata_o equals ram_rdata_i, and ram_we_o follows wr_i.
- R9: After reset the ROM bank is 1, the RAM bank is 0, the mode is 0 and RAM is disabled.
- R10: A control write takes effect at the clock edge where wr_i is high. The next cycle's address is mapped with the new value.
- R11: Writes to addresses 0x8000 and above leave all control registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| wr_i | input | 1 | CPU write strobe |
| ram_rdata_i | input | 8 | Read data from external RAM |
| rom_addr_o | output | ROM_AW | Physical ROM byte address |
| ram_addr_o | output | 15 | Physical RAM byte address |
| ram_ce_o | output | 1 | External RAM chip enable |
| ram_we_o | output | 1 | External RAM write enable |
| rdata_o | output | 8 | RAM window read data as seen by the CPU |

## Verification
The bench builds two instances side by side. One uses the default 128 banks, which exposes all seven bank bits and the full mode-0 upper field. The other uses 8 banks, so every bank number above 7 lands in the wrap path and the upper field is masked out completely. Together they allow a full sweep of the lower field, of the 2-bit register in both modes, and of all 256 enable data values, each checked arithmetically against both instances.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  localparam int unsigned BANK_MAX_W = 7;
  localparam int unsigned RAM_AW     = 15;

  // decode of addr[14:13] inside 0x0000-0x7FFF
  typedef enum logic [1:0] {
    CTL_RAM_GATE = 2'd0,
    CTL_BANK_LO  = 2'd1,
    CTL_BANK_HI  = 2'd2,
    CTL_MODE     = 2'd3
  } ctl_sel_e;

  typedef struct packed {
    logic       ram_en;
    logic       mode;
    logic [1:0] upper;
    logic [4:0] lo;
  } ctl_state_t;
endpackage

// File: rtl/mbc_ctl_regs.sv
module mbc_ctl_regs
  import mbc_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ctl_wr_i,
  input  ctl_sel_e              sel_i,
  input  logic [7:0]            wdata_i,
  output logic [BANK_MAX_W-1:0] rom_bank_o,
  output logic [1:0]            ram_bank_o,
  output logic                  ram_en_o
);
  ctl_state_t st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q.ram_en <= 1'b0;
      st_q.mode   <= 1'b0;
      st_q.upper  <= 2'd0;
      st_q.lo     <= 5'd1;
    end else if (ctl_wr_i) begin
      unique case (sel_i)
        CTL_RAM_GATE: begin
          if (wdata_i == 8'h0A)      st_q.ram_en <= 1'b1;
          else if (wdata_i == 8'h00) st_q.ram_en <= 1'b0;
        end
        CTL_BANK_LO: st_q.lo <= (wdata_i[4:0] == 5'd0) ? 5'd1 : wdata_i[4:0];
        CTL_BANK_HI: st_q.upper <= wdata_i[1:0];
        CTL_MODE: begin
          // leaving either mode drops what the shared field meant there
          if (wdata_i[0] != st_q.mode) st_q.upper <= 2'd0;
          st_q.mode <= wdata_i[0];
        end
        default: ;
      endcase
    end
  end

  assign rom_bank_o = {(st_q.mode ? 2'd0 : st_q.upper), st_q.lo};
  assign ram_bank_o = st_q.mode ? st_q.upper : 2'd0;
  assign ram_en_o   = st_q.ram_en;

  a_r1_gate_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && sel_i == CTL_RAM_GATE && wdata_i != 8'h0A && wdata_i != 8'h00)
      |=> $stable(ram_en_o));
  a_r2_lo_zero_is_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && sel_i == CTL_BANK_LO && wdata_i[4:0] == 5'd0) |=> (rom_bank_o[4:0] == 5'd1));
  a_r5_mode_change_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && sel_i == CTL_MODE && wdata_i[0] != st_q.mode)
      |=> (rom_bank_o[6:5] == 2'd0 && ram_bank_o == 2'd0));
  a_r11_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_wr_i |=> ($stable(rom_bank_o) && $stable(ram_bank_o) && $stable(ram_en_o)));
endmodule

// File: rtl/mbc_rom_map.sv
module mbc_rom_map
  import mbc_pkg::*;
#(
  parameter int unsigned ROM_BANKS = 128,
  localparam int unsigned BANK_W   = $clog2(ROM_BANKS),
  localparam int unsigned ROM_AW   = BANK_W + 14
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [14:0]           addr_i,
  input  logic [BANK_MAX_W-1:0] bank_i,
  output logic [ROM_AW-1:0]     rom_addr_o
);
  logic [BANK_W-1:0] bank_eff;

  // power-of-two size: truncation is the wrap mask
  assign bank_eff   = bank_i[BANK_W-1:0];
  assign rom_addr_o = {(addr_i[14] ? bank_eff : {BANK_W{1'b0}}), addr_i[13:0]};

  a_r6_fixed_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i[14] |-> (rom_addr_o[ROM_AW-1:14] == '0));
  a_r7_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_addr_o[13:0] == addr_i[13:0]);
endmodule

// File: rtl/mbc_ram_map.sv
module mbc_ram_map
  import mbc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       addr_i,
  input  logic              wr_i,
  input  logic [1:0]        bank_i,
  input  logic              en_i,
  input  logic [7:0]        ram_rdata_i,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              ram_ce_o,
  output logic              ram_we_o,
  output logic [7:0]        rdata_o
);
  logic in_win;

  assign in_win     = (addr_i[15:13] == 3'b101);
  assign ram_ce_o   = in_win && en_i;
  assign ram_we_o   = ram_ce_o && wr_i;
  assign ram_addr_o = {bank_i, addr_i[12:0]};
  assign rdata_o    = ram_ce_o ? ram_rdata_i : 8'hFF;

  a_r8_off_no_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!ram_ce_o && !ram_we_o));
  a_r8_off_reads_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && !en_i) |-> (rdata_o == 8'hFF));
endmodule

// File: rtl/mbc_bank_ctrl.sv
module mbc_bank_ctrl
  import mbc_pkg::*;
#(
  parameter int unsigned ROM_BANKS = 128,
  localparam int unsigned ROM_AW   = $clog2(ROM_BANKS) + 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_i,
  input  logic [7:0]        ram_rdata_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic [14:0]       ram_addr_o,
  output logic              ram_ce_o,
  output logic              ram_we_o,
  output logic [7:0]        rdata_o
);
  logic                  ctl_wr;
  logic [BANK_MAX_W-1:0] rom_bank;
  logic [1:0]            ram_bank;
  logic                  ram_en;

  assign ctl_wr = wr_i && !addr_i[15];

  mbc_ctl_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_wr_i   (ctl_wr),
    .sel_i      (ctl_sel_e'(addr_i[14:13])),
    .wdata_i    (wdata_i),
    .rom_bank_o (rom_bank),
    .ram_bank_o (ram_bank),
    .ram_en_o   (ram_en)
  );

  mbc_rom_map #(.ROM_BANKS(ROM_BANKS)) u_rom (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i[14:0]),
    .bank_i     (rom_bank),
    .rom_addr_o (rom_addr_o)
  );

  mbc_ram_map u_ram (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .wr_i        (wr_i),
    .bank_i      (ram_bank),
    .en_i        (ram_en),
    .ram_rdata_i (ram_rdata_i),
    .ram_addr_o  (ram_addr_o),
    .ram_ce_o    (ram_ce_o),
    .ram_we_o    (ram_we_o),
    .rdata_o     (rdata_o)
  );

  a_r4_ram_bank_mode0_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_bank[6:5] != 2'd0) |-> (ram_addr_o[14:13] == 2'd0));
endmodule

// File: tb/mbc_bank_ctrl_test.sv
`timescale 1ns/1ps
module mbc_bank_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wdata = 8'h00;
  logic        wr = 1'b0;
  logic [7:0]  rdin = 8'h5A;

  logic [20:0] rom_a;
  logic [14:0] ram_a;
  logic        ce, we;
  logic [7:0]  rd;
  logic [16:0] rom_s;
  logic [14:0] ram_s;
  logic        ce_s, we_s;
  logic [7:0]  rd_s;

  int checks = 0;
  int errors = 0;

  // bench model
  logic       m_en = 1'b0, m_mode = 1'b0;
  logic [1:0] m_up = 2'd0;
  logic [4:0] m_lo = 5'd1;

  always #2.5 clk = ~clk;

  mbc_bank_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr),
    .ram_rdata_i(rdin), .rom_addr_o(rom_a), .ram_addr_o(ram_a),
    .ram_ce_o(ce), .ram_we_o(we), .rdata_o(rd));

  mbc_bank_ctrl #(.ROM_BANKS(8)) uut_small (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr),
    .ram_rdata_i(rdin), .rom_addr_o(rom_s), .ram_addr_o(ram_s),
    .ram_ce_o(ce_s), .ram_we_o(we_s), .rdata_o(rd_s));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h act=%h exp=%h", req, addr, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    if (!a[15]) begin
      case (a[14:13])
        2'd0: if (d == 8'h0A) m_en = 1'b1; else if (d == 8'h00) m_en = 1'b0;
        2'd1: m_lo = (d[4:0] == 5'd0) ? 5'd1 : d[4:0];
        2'd2: m_up = d[1:0];
        default: begin
          if (d[0] != m_mode) m_up = 2'd0;
          m_mode = d[0];
        end
      endcase
    end
    @(negedge clk);
    wr = 1'b0;
  endtask

  // map one address and compare with the model
  task automatic probe(input string req, input logic [15:0] a);
    logic [6:0] bank;
    logic       in_ram;
    addr = a; wr = 1'b0;
    #1;
    bank = {(m_mode ? 2'd0 : m_up), m_lo};
    in_ram = (a >= 16'hA000 && a <= 16'hBFFF);
    if (a < 16'h8000) begin
      chk(req, 32'(rom_a), a[14] ? {11'd0, bank, a[13:0]} : {18'd0, a[13:0]});
      chk(req, 32'(rom_s), a[14] ? {15'd0, bank[2:0], a[13:0]} : {18'd0, a[13:0]});
    end
    if (in_ram) begin
      chk(req, 32'(ce), 32'(m_en));
      chk(req, 32'(ce_s), 32'(m_en));
      chk(req, 32'(rd), m_en ? 32'(rdin) : 32'hFF);
      if (m_en) chk(req, 32'(ram_a), {17'd0, (m_mode ? m_up : 2'd0), a[12:0]});
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    addr = 16'h4000; #1;
    chk("R9", 32'(rom_a), {11'd0, 7'd1, 14'd0});
    addr = 16'hA000; #1;
    chk("R9", 32'(ce), 0);
    chk("R9", 32'(ram_a), {17'd0, 15'h0000});
    probe("R6", 16'h0000);
    probe("R6", 16'h3FFF);
    probe("R7", 16'h7FFF);

    // R8 disabled window
    addr = 16'hB123; wdata = 8'h77; wr = 1'b1; #1;
    chk("R8", 32'(we), 0);
    chk("R8", 32'(rd), 32'hFF);
    @(negedge clk); wr = 1'b0;

    // R1 sweep over all data values, toggling back each time
    for (int d = 0; d < 256; d++) begin
      cpu_wr(16'h0000, 8'h0A);
      cpu_wr(16'h1FFF, 8'(d));
      probe("R1", 16'hA000);
      cpu_wr(16'h0123, 8'h00);
      cpu_wr(16'h1000, 8'(d));
      probe("R1", 16'hBFFF);
    end

    // R2 lower field sweep in mode 0 with upper bits set
    cpu_wr(16'h4000, 8'h03);
    for (int d = 0; d < 64; d++) begin
      cpu_wr(16'h2000 + 16'(d * 64), 8'(d * 33 + 7));
      cpu_wr(16'h2000, 8'(d));
      probe("R2", 16'h4000 + 16'(d * 251));
      probe("R10", 16'h7FFF);
    end

    // R3 upper field in mode 0
    cpu_wr(16'h0000, 8'h0A);
    for (int u = 0; u < 8; u++) begin
      cpu_wr(16'h5FFF, 8'(u * 5));
      probe("R3", 16'h6ABC);
      probe("R3", 16'hA555);
      probe("R6", 16'h2ABC);
    end

    // R5 enter mode 1: upper cleared
    cpu_wr(16'h4000, 8'h02);
    cpu_wr(16'h6000, 8'h01);
    probe("R5", 16'h4001);
    chk("R5", 32'(rom_a[20:19]), 0);
    // R4 ram bank sweep in mode 1
    for (int u = 0; u < 4; u++) begin
      cpu_wr(16'h4000, 8'(u));
      probe("R4", 16'hA000 + 16'(u * 1111));
      probe("R4", 16'h7000);
    end
    // R5 rewrite same mode keeps field
    cpu_wr(16'h7FFF, 8'h03);
    probe("R5", 16'hBFFF);
    chk("R5", 32'(ram_a[14:13]), 3);
    // R5 back to mode 0: ram bank zero
    cpu_wr(16'h6000, 8'h00);
    probe("R5", 16'hA010);
    chk("R5", 32'(ram_a[14:13]), 0);

    // R8 enabled write strobe passes through
    @(negedge clk);
    addr = 16'hA321; wr = 1'b1; rdin = 8'hC3; #1;
    chk("R8", 32'(we), 1);
    chk("R8", 32'(rd), 32'hC3);
    @(negedge clk); wr = 1'b0;

    // R11 writes above 0x7FFF leave control unchanged
    cpu_wr(16'h2000, 8'h15);
    cpu_wr(16'h4000, 8'h01);
    for (int k = 0; k < 16; k++) begin
      cpu_wr(16'h8000 + 16'(k * 16'h0800), 8'(k * 17));
      probe("R11", 16'h4444);
      probe("R11", 16'hA444);
    end

    // R7 wrap on small instance for all lower values in mode 1
    cpu_wr(16'h6000, 8'h01);
    for (int d = 1; d < 32; d++) begin
      cpu_wr(16'h3000, 8'(d));
      probe("R7", 16'h5555);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule